// File: doc/BRIEF.md
# Phase Interpolator Code Loader

This block steers the phase interpolator of a serial transmitter lane to a requested 7-bit phase code. After reset it brings the interpolator out of power-down and into override mode by raising five control outputs one at a time. Each control is held for a programmable settling count before the next one moves. From then on the block takes code requests on a valid/ready handshake. It places each code in an 8-bit configuration register through a simple register write port.

A code only takes effect when it is written three times with the same low seven bits. The top bit of the byte acts as a load strobe and goes low, then high, then low. Each write is a one-cycle strobe with fixed address and data. The block waits for a ready pulse from the register port before it moves on. If the port stays silent for too long, the block gives up the load and raises an error flag that stays set. The power-up order runs only once per reset; later codes repeat only the three writes.

Top module: `phi_code_loader`

## Requirements
- R1: While reset is high and in the cycle after it, pi_pwrdn is 1, pi_synfreq0, pi_enable, pi_override, pi_select, init_done, busy, done, err, req_ready and reg_wr are all 0.
- R2: After reset is released, the controls change in a fixed order: pi_pwrdn falls, then pi_synfreq0 rises, then pi_enable, then pi_override, then pi_select. Step k (k = 0..4) takes effect at clock edge 1 + k*SETTLE counted from the first edge with reset low, so each control is held for SETTLE cycles (SETTLE >= 2).
- R3: init_done rises at edge 5*SETTLE after reset release and stays high until the next reset.
- R4: req_ready is high only when init_done is high and no load is in progress. A request presented while req_ready is low is dropped and produces no register write.
- R5: An accepted code C produces exactly three writes to address CFG_ADDR with data {1'b0,C}, {1'b1,C}, {1'b0,C}, in that order (code 0x20 gives 0x20, 0xA0, 0x20).
- R6: reg_wr is high for exactly one cycle per write, and the byte is held until ready arrives. A ready that comes during the strobe cycle itself is not taken as an acknowledge. Bits 6:0 are equal to the accepted code in every write of one load.
- R7: busy is high from the edge that accepts a request until the edge that takes the third ready. done pulses for one cycle at that same edge. With every ready arriving d cycles after its strobe (d >= 1), the load takes 6 + 3*d cycles.
- R8: A ready is taken in any of the TIMEOUT cycles after a strobe. If none arrives, busy falls 2 + TIMEOUT cycles after acceptance, err rises, done stays low and no further write of that load is issued.
- R9: err stays high until reset. Later requests are still accepted and complete normally.
- R10: Reset during a load ends it at once, returns every control to its safe value, clears err and starts the power-up order again.
- R11: Once init_done is high, the five controls do not change until the next reset, however many loads follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Code request valid |
| req_code | input | 7 | Requested phase code |
| req_ready | output | 1 | Block can accept a request |
| pi_pwrdn | output | 1 | Interpolator power-down (1 = off) |
| pi_synfreq0 | output | 1 | Synthesis-frequency flag, bit 0 |
| pi_enable | output | 1 | Interpolator enable |
| pi_override | output | 1 | Direct code override enable |
| pi_select | output | 1 | Interpolator source select |
| init_done | output | 1 | Power-up order complete |
| reg_addr | output | ADDR_W | Register port address (constant CFG_ADDR) |
| reg_wdata | output | 8 | Register port write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdy | input | 1 | Write acknowledge pulse |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse when a load completes |
| err | output | 1 | Sticky write timeout flag |

## Verification
A fault in the power-up counter shows on the control pins within one settling window, as an edge in the wrong cycle or in the wrong order. The bench compares those pins against a count of cycles since reset on every clock. A wrong phase index or a corrupted code latch shows on the register port at the next strobe as a misplaced bit 7 or changed low bits. The bench checks each byte against a queue of expected bytes. A miscounted wait or timeout moves the falling edge of busy away from 6 + 3*d or 2 + TIMEOUT cycles, and the bench checks that edge to the exact cycle.

// File: rtl/phi_pkg.sv
package phi_pkg;

  localparam int N_CTRL = 5;
  localparam int N_WRITES = 3;

  typedef enum logic [1:0] {
    W_IDLE,
    W_STROBE,
    W_WAIT
  } wr_state_t;

  typedef enum logic [1:0] {
    L_IDLE,
    L_ISSUE,
    L_WAIT
  } ld_state_t;

  // Byte for one write: load strobe on top, code below.
  function automatic logic [7:0] cfg_byte(input logic strobe, input logic [6:0] code);
    return {strobe, code};
  endfunction

  // The middle write of a load carries the strobe bit.
  function automatic logic strobe_of_phase(input logic [1:0] phase);
    return (phase == 2'd1);
  endfunction

  function automatic logic last_phase(input logic [1:0] phase);
    return (phase == 2'(N_WRITES - 1));
  endfunction

endpackage

// File: rtl/phi_enable_seq.sv
module phi_enable_seq #(
  parameter int SETTLE = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic [phi_pkg::N_CTRL-1:0] ctrl_mask,
  output logic                      init_done
);
  import phi_pkg::*;

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);
  localparam logic [N_CTRL-1:0] ALL_ON = {N_CTRL{1'b1}};

  logic [CW-1:0] hold_cnt;
  logic          step_now;
  logic          window_end;

  assign step_now   = (hold_cnt == '0);
  assign window_end = (hold_cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_mask <= '0;
      hold_cnt  <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (step_now) ctrl_mask <= {ctrl_mask[N_CTRL-2:0], 1'b1};
      hold_cnt <= window_end ? '0 : hold_cnt + 1'b1;
      if (window_end && ctrl_mask == ALL_ON) init_done <= 1'b1;
    end
  end

  // Each control may only be on if every earlier one is already on.
  for (genvar k = 0; k < N_CTRL - 1; k++) begin : g_order
    p_order_r2: assert property (@(posedge clk) disable iff (rst)
      ctrl_mask[k+1] |-> ctrl_mask[k]);
  end

  p_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done && $stable(ctrl_mask));

  p_done_full_r3: assert property (@(posedge clk) disable iff (rst)
    init_done |-> ctrl_mask == ALL_ON);

endmodule

// File: rtl/phi_reg_writer.sv
module phi_reg_writer #(
  parameter int TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] data_in,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  input  logic       reg_rdy,
  output logic       ack,
  output logic       tmo
);
  import phi_pkg::*;

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

  wr_state_t     st;
  logic [TW-1:0] wait_cnt;
  logic          waiting;

  assign waiting = (st == W_WAIT);
  assign reg_wr  = (st == W_STROBE);
  assign ack     = waiting && reg_rdy;
  assign tmo     = waiting && !reg_rdy && (wait_cnt == T_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      wait_cnt  <= '0;
      reg_wdata <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          reg_wdata <= data_in;
          st        <= W_STROBE;
        end
        W_STROBE: begin
          wait_cnt <= '0;
          st       <= W_WAIT;
        end
        W_WAIT: begin
          if (ack || tmo) st <= W_IDLE;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  p_strobe_one_r6: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  p_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    waiting |-> $stable(reg_wdata));

  p_strobe_then_wait_r6: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> waiting);

endmodule

// File: rtl/phi_load_seq.sv
module phi_load_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       init_done,
  input  logic       req_valid,
  input  logic [6:0] req_code,
  output logic       req_ready,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [6:0] code_q,
  output logic       wr_start,
  output logic [7:0] wr_data,
  input  logic       wr_ack,
  input  logic       wr_tmo
);
  import phi_pkg::*;

  ld_state_t  st;
  logic [1:0] phase;
  logic       accept;

  assign req_ready = init_done && (st == L_IDLE);
  assign accept    = req_valid && req_ready;
  assign wr_start  = (st == L_ISSUE);
  assign wr_data   = cfg_byte(strobe_of_phase(phase), code_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= L_IDLE;
      phase  <= '0;
      code_q <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        L_IDLE: if (accept) begin
          code_q <= req_code;
          phase  <= '0;
          busy   <= 1'b1;
          st     <= L_ISSUE;
        end
        L_ISSUE: st <= L_WAIT;
        L_WAIT: begin
          if (wr_ack) begin
            if (last_phase(phase)) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= L_IDLE;
            end else begin
              phase <= phase + 1'b1;
              st    <= L_ISSUE;
            end
          end else if (wr_tmo) begin
            err  <= 1'b1;
            busy <= 1'b0;
            st   <= L_IDLE;
          end
        end
        default: st <= L_IDLE;
      endcase
    end
  end

  p_busy_init_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> init_done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: rtl/phi_code_loader.sv
module phi_code_loader #(
  parameter int              SETTLE   = 4,
  parameter int              TIMEOUT  = 64,
  parameter int              ADDR_W   = 9,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h09C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [6:0]        req_code,
  output logic              req_ready,
  output logic              pi_pwrdn,
  output logic              pi_synfreq0,
  output logic              pi_enable,
  output logic              pi_override,
  output logic              pi_select,
  output logic              init_done,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_wr,
  input  logic              reg_rdy,
  output logic              busy,
  output logic              done,
  output logic              err
);
  import phi_pkg::*;

  logic [N_CTRL-1:0] ctrl_mask;
  logic [6:0]        ld_code;
  logic              wr_start;
  logic [7:0]        wr_data;
  logic              wr_ack;
  logic              wr_tmo;

  phi_enable_seq #(.SETTLE(SETTLE)) u_enable (
    .clk       (clk),
    .rst       (rst),
    .ctrl_mask (ctrl_mask),
    .init_done (init_done)
  );

  phi_load_seq u_load (
    .clk       (clk),
    .rst       (rst),
    .init_done (init_done),
    .req_valid (req_valid),
    .req_code  (req_code),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .code_q    (ld_code),
    .wr_start  (wr_start),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .wr_tmo    (wr_tmo)
  );

  phi_reg_writer #(.TIMEOUT(TIMEOUT)) u_writer (
    .clk       (clk),
    .rst       (rst),
    .start     (wr_start),
    .data_in   (wr_data),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdy   (reg_rdy),
    .ack       (wr_ack),
    .tmo       (wr_tmo)
  );

  // Step 0 clears power-down; steps 1..4 raise the remaining controls.
  assign pi_pwrdn    = ~ctrl_mask[0];
  assign pi_synfreq0 = ctrl_mask[1];
  assign pi_enable   = ctrl_mask[2];
  assign pi_override = ctrl_mask[3];
  assign pi_select   = ctrl_mask[4];
  assign reg_addr    = CFG_ADDR;

  p_code_fixed_r6: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> reg_wdata[6:0] == ld_code);

  p_ctrl_on_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!pi_pwrdn && pi_enable && pi_override && pi_select));

  p_no_write_idle_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> busy);

endmodule

// File: tb/phi_code_loader_tb.sv
module phi_code_loader_tb;

  localparam int S  = 4;
  localparam int T  = 16;
  localparam int AW = 9;
  localparam logic [AW-1:0] ADDR = 9'h09C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [6:0] req_code = '0;
  logic reg_rdy = 1'b0;
  logic req_ready, pi_pwrdn, pi_synfreq0, pi_enable, pi_override, pi_select;
  logic init_done, reg_wr, busy, done, err;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata;

  always #4 clk = ~clk;

  phi_code_loader #(.SETTLE(S), .TIMEOUT(T), .ADDR_W(AW), .CFG_ADDR(ADDR)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .req_ready(req_ready), .pi_pwrdn(pi_pwrdn), .pi_synfreq0(pi_synfreq0),
    .pi_enable(pi_enable), .pi_override(pi_override), .pi_select(pi_select),
    .init_done(init_done), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdy(reg_rdy), .busy(busy), .done(done), .err(err)
  );

  int tests = 0;
  int fails = 0;
  int since = 0;
  int wr_count = 0;
  int rsp_delay = 1;
  int pend = -1;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycles since reset release, counted at each edge.
  always @(posedge clk) since <= rst ? 0 : since + 1;

  // Per-clock reference for the power-up controls.
  always @(negedge clk) begin
    if (!finished) begin
      logic [4:0] m;
      for (int k = 0; k < 5; k++) m[k] = (since >= 1 + k * S);
      chk({pi_select, pi_override, pi_enable, pi_synfreq0, ~pi_pwrdn} == m,
          "R2/R11 controls", {pi_select, pi_override, pi_enable, pi_synfreq0, ~pi_pwrdn}, m);
      chk(init_done == (since >= 5 * S), "R3 init_done", init_done, since >= 5 * S);
    end
  end

  // Register port responder and write checker.
  always @(negedge clk) begin
    reg_rdy = 1'b0;
    if (rst) pend = -1;
    else if (pend == 0) begin reg_rdy = 1'b1; pend = -1; end
    else if (pend > 0) pend--;
    if (reg_wr && !rst) begin
      logic [7:0] e;
      wr_count++;
      chk(reg_addr == ADDR, "R5 address", reg_addr, ADDR);
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", reg_wdata, 0);
      else begin
        e = exp_q.pop_front();
        chk(reg_wdata == e, "R5/R6 write data", reg_wdata, e);
      end
      if (rsp_delay == 0) reg_rdy = 1'b1;
      else if (rsp_delay > 0) pend = rsp_delay - 1;
    end
  end

  task automatic do_load(input logic [6:0] code, input int d, input bit ok, input bit poke);
    int n;
    int want;
    rsp_delay = d;
    for (int i = 0; i < 1000 && !req_ready; i++) @(negedge clk);
    exp_q.push_back({1'b0, code});
    if (ok) begin
      exp_q.push_back({1'b1, code});
      exp_q.push_back({1'b0, code});
    end
    req_code = code;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    n = 0;
    while (busy && n < 2000) begin
      if (poke) begin
        chk(req_ready == 1'b0, "R4 ready while busy", req_ready, 0);
        req_valid = 1'b1;
        req_code = 7'h44;
      end
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    want = ok ? 6 + 3 * d : 2 + T;
    chk(n == want, ok ? "R7 load length" : "R8 timeout length", n, want);
    chk(done == ok, ok ? "R7 done pulse" : "R8 no done on timeout", done, ok);
    if (!ok) chk(err == 1'b1, "R8 err set", err, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    chk(exp_q.size() == 0, "R5 three writes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic check_safe(input string req);
    chk({pi_pwrdn, pi_synfreq0, pi_enable, pi_override, pi_select} == 5'b10000,
        req, {pi_pwrdn, pi_synfreq0, pi_enable, pi_override, pi_select}, 5'b10000);
    chk({init_done, busy, done, err, req_ready, reg_wr} == 6'b0, req,
        {init_done, busy, done, err, req_ready, reg_wr}, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_safe("R1 reset state");
    rst = 1'b0;
    // Requests during power-up are dropped (R4).
    req_valid = 1'b1;
    req_code = 7'h55;
    for (int i = 0; i < 5 * S - 2; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R4 not ready before init", req_ready, 0);
    end
    req_valid = 1'b0;
    while (!init_done) @(negedge clk);
    chk(wr_count == 0, "R4 no write before init", wr_count, 0);

    do_load(7'h20, 1, 1, 0);
    do_load(7'h7F, 3, 1, 0);
    do_load(7'h00, 2, 1, 0);
    do_load(7'h01, T, 1, 0);       // ready on the last allowed cycle (R8)
    do_load(7'h33, 4, 1, 1);       // requests during busy ignored (R4)
    chk(err == 1'b0, "R8 no err yet", err, 0);

    do_load(7'h12, -1, 0, 0);      // no ready at all (R8)
    do_load(7'h2A, 0, 0, 0);       // ready only in strobe cycle (R6)
    do_load(7'h15, 1, 1, 0);       // still works after error (R9)
    chk(err == 1'b1, "R9 err sticky", err, 1);

    // Reset in the middle of a load (R10).
    rsp_delay = 5;
    exp_q.push_back(8'h66);
    req_code = 7'h66;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    exp_q.delete();
    check_safe("R10 reset mid-load");
    rst = 1'b0;
    @(negedge clk);
    chk(pi_pwrdn == 1'b0 && pi_synfreq0 == 1'b0, "R10 order restarts",
        {pi_pwrdn, pi_synfreq0}, 2'b00);
    while (!init_done) @(negedge clk);
    do_load(7'h0A, 1, 1, 0);
    chk(err == 1'b0, "R10 err cleared", err, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule